// File: doc/BRIEF.md
# Four-Direction Semi-Global Cost Aggregator

This block smooths a stereo matching-cost volume. It takes one cost vector per pixel in raster order. Each vector holds one matching cost for every candidate disparity. For each pixel, the block applies the semi-global path recursion along four directions that agree with the scan order. The predecessor pixel for each direction is:
- the left neighbour,
- the upper-left neighbour,
- the upper neighbour,
- the upper-right neighbour.

For every disparity, the block returns the sum of the four path costs. The recursion uses two penalties: a small one for a one-step disparity change and a large one for any larger jump. Both penalties are inputs, so the surrounding pipeline can tune smoothing per frame.

The horizontal path state is held in a register. The other three directions keep the previous row of path vectors in line buffers. Each buffer entry packs a whole vector into one word, so a single read and a single write per pixel serve all disparities. The block accepts one full vector per clock through a valid/ready handshake. It produces the aggregate through a single output register.

Top module: `sgm_agg4`

## Requirements
- R1: `in_ready` is high whenever the output register is empty or being drained. An accepted vector's aggregate appears on `out_sum` with `out_valid` in the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sum` hold their values.
- R2: For the first pixel of every frame, no direction has a predecessor, so every disparity's aggregate equals four times its input cost.
- R3: Every path cost L(p,d) lies between C(p,d) and C(p,d)+P2. Here P2 is the large penalty.
- R4: A direction whose predecessor falls outside the image restarts at the input cost. This applies to the left path in column 0, to the three upper paths in row 0, to the upper-left path in column 0 and to the upper-right path in the last column.
- R5: Otherwise, L(p,d) = C(p,d) + min(L'(d), L'(d-1)+P1, L'(d+1)+P1, m+P2) - m. Here L' is the predecessor's path vector, m is its minimum over all disparities and P1 is the small penalty. The d-1 term is dropped at d=0 and the d+1 term is dropped at the last disparity.
- R6: The output packs disparity d as the sum of the four path costs at bits [d*SW +: SW], with SW equal to the path width plus 2. Input costs are packed at [d*CW +: CW].
- R7: After IMG_W*IMG_H accepted vectors, the raster position wraps, and the next vector is treated as the first pixel of a new frame.
- R8: Both penalties come from the `pen_small` and `pen_large` inputs. With both at zero, every path cost equals the input cost, so the aggregate is four times the input.
- R9: Cycles without an accepted vector change no path state, raster position or line-buffer content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input cost vector present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_cost | input | DMAX*CW | Packed matching costs, disparity d at [d*CW +: CW] |
| pen_small | input | PENW | Penalty for a one-step disparity change |
| pen_large | input | PENW | Penalty for a larger disparity jump |
| out_valid | output | 1 | Aggregate present |
| out_ready | input | 1 | Consumer takes the aggregate |
| out_sum | output | DMAX*SW | Packed aggregate costs, disparity d at [d*SW +: SW] |

## Verification
The assertions check three properties on every cycle:
- each freshly computed path value stays between its input cost and that cost plus the large penalty;
- the raster position stays inside the image and wraps to the origin after the last pixel;
- a stalled output holds steady.

The exact recursion values, the restarts at the image edges, the dropped terms at both ends of the disparity range, the penalty dependence and the immunity to idle input cycles can only be shown by the bench. It compares every aggregate against a frame-level model under several cost patterns and penalty settings, with random output back-pressure and input gaps.

// File: rtl/sgm_agg_pkg.sv
package sgm_agg_pkg;

    typedef enum logic [1:0] {
        DIR_LEFT  = 2'd0,
        DIR_UPL   = 2'd1,
        DIR_UP    = 2'd2,
        DIR_UPR   = 2'd3
    } sgm_dir_e;

    localparam int NDIR = 4;

    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // path width: widest of cost and penalty, plus one bit so C + P2 fits
    function automatic int path_bits(input int cw, input int penw);
        return ((cw > penw) ? cw : penw) + 1;
    endfunction

endpackage

// File: rtl/sgm_raster_pos.sv
module sgm_raster_pos #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    parameter int XW    = 3,
    parameter int YW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [XW-1:0] col,
    output logic [YW-1:0] row,
    output logic          is_first_col,
    output logic          is_last_col,
    output logic          is_first_row
);
    localparam logic [XW-1:0] COL_END = XW'(IMG_W - 1);
    localparam logic [YW-1:0] ROW_END = YW'(IMG_H - 1);

    assign is_first_col = (col == '0);
    assign is_last_col  = (col == COL_END);
    assign is_first_row = (row == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (is_last_col) begin
                col <= '0;
                row <= (row == ROW_END) ? '0 : row + YW'(1);
            end else begin
                col <= col + XW'(1);
            end
        end
    end

    assert_pos_in_image_R7: assert property (@(posedge clk) disable iff (rst)
        (col <= COL_END) && (row <= ROW_END));

    assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (step && is_last_col && row == ROW_END) |=> (col == '0 && row == '0));

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(col) && $stable(row)));

endmodule

// File: rtl/sgm_line_buf.sv
module sgm_line_buf #(
    parameter int DEPTH = 8,
    parameter int WW    = 32,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [WW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [WW-1:0] rd_data
);
    logic [WW-1:0] mem [DEPTH];

    // read returns the stored word; a write in the same cycle lands after it
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assert_write_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/sgm_path_step.sv
module sgm_path_step #(
    parameter int DMAX = 8,
    parameter int CW   = 6,
    parameter int PENW = 6,
    parameter int PW   = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chk,
    input  logic [DMAX*CW-1:0] cost_i,
    input  logic [DMAX*PW-1:0] prev_i,
    input  logic               prev_ok,
    input  logic [PENW-1:0]    p_small,
    input  logic [PENW-1:0]    p_large,
    output logic [DMAX*PW-1:0] path_o
);
    logic [PW-1:0] cst [DMAX];
    logic [PW-1:0] prv [DMAX];
    logic [PW-1:0] p1x, p2x, pmin;

    function automatic logic [PW-1:0] sadd(input logic [PW-1:0] a, input logic [PW-1:0] b);
        logic [PW:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[PW] ? {PW{1'b1}} : t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] vmin(input logic [PW-1:0] a, input logic [PW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    assign p1x = {{(PW-PENW){1'b0}}, p_small};
    assign p2x = {{(PW-PENW){1'b0}}, p_large};

    genvar gd;
    generate
        for (gd = 0; gd < DMAX; gd++) begin : g_unpack
            assign cst[gd] = {{(PW-CW){1'b0}}, cost_i[gd*CW +: CW]};
            assign prv[gd] = prev_i[gd*PW +: PW];
        end
    endgenerate

    always_comb begin
        pmin = prv[0];
        for (int i = 1; i < DMAX; i++) pmin = vmin(pmin, prv[i]);
    end

    generate
        for (gd = 0; gd < DMAX; gd++) begin : g_disp
            logic [PW-1:0] cand;
            always_comb begin
                cand = vmin(prv[gd], sadd(pmin, p2x));
                if (gd > 0)        cand = vmin(cand, sadd(prv[(gd > 0) ? gd-1 : 0], p1x));
                if (gd < DMAX - 1) cand = vmin(cand, sadd(prv[(gd < DMAX-1) ? gd+1 : gd], p1x));
            end
            // cand never drops below pmin, so the difference is non-negative
            assign path_o[gd*PW +: PW] = prev_ok ? sadd(cst[gd], cand - pmin) : cst[gd];

            assert_path_floor_R3: assert property (@(posedge clk) disable iff (rst)
                chk |-> (path_o[gd*PW +: PW] >= cst[gd]));
            assert_path_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
                chk |-> (path_o[gd*PW +: PW] <= sadd(cst[gd], p2x)));
        end
    endgenerate

endmodule

// File: rtl/sgm_agg4.sv
module sgm_agg4
    import sgm_agg_pkg::*;
#(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    parameter int DMAX  = 8,
    parameter int CW    = 6,
    parameter int PENW  = 6,
    localparam int PW   = path_bits(CW, PENW),
    localparam int SW   = PW + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DMAX*CW-1:0] in_cost,
    input  logic [PENW-1:0]    pen_small,
    input  logic [PENW-1:0]    pen_large,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DMAX*SW-1:0] out_sum
);
    localparam int XW = bits_for(IMG_W);
    localparam int YW = bits_for(IMG_H);
    localparam int VW = DMAX * PW;

    logic          in_fire;
    logic [XW-1:0] col;
    logic [YW-1:0] row;
    logic          first_col, last_col, first_row;

    logic [VW-1:0] path_v   [NDIR];
    logic [VW-1:0] prev_v   [NDIR];
    logic          prev_ok  [NDIR];
    logic [VW-1:0] lb_rd    [NDIR];
    logic [VW-1:0] left_reg;
    logic [VW-1:0] upl_hold;
    logic [DMAX*SW-1:0] sum_now;

    assign in_ready = !out_valid || out_ready;
    assign in_fire  = in_valid && in_ready;

    sgm_raster_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW)) u_pos (
        .clk(clk), .rst(rst), .step(in_fire),
        .col(col), .row(row),
        .is_first_col(first_col), .is_last_col(last_col), .is_first_row(first_row)
    );

    genvar g;
    generate
        for (g = 0; g < NDIR; g++) begin : g_dir
            if (g == int'(DIR_LEFT)) begin : g_left
                assign lb_rd[g]   = '0;
                assign prev_v[g]  = left_reg;
                assign prev_ok[g] = !first_col;
            end else begin : g_row
                logic [XW-1:0] rd_addr;
                // upper-right looks one column ahead; the rest read their own column
                if (g == int'(DIR_UPR)) begin : g_ahead
                    assign rd_addr = last_col ? col : col + XW'(1);
                end else begin : g_same
                    assign rd_addr = col;
                end
                sgm_line_buf #(.DEPTH(IMG_W), .WW(VW), .AW(XW)) u_lb (
                    .clk(clk), .rst(rst), .wr_en(in_fire), .wr_addr(col),
                    .wr_data(path_v[g]), .rd_addr(rd_addr), .rd_data(lb_rd[g])
                );
                if (g == int'(DIR_UPL)) begin : g_upl
                    assign prev_v[g]  = upl_hold;
                    assign prev_ok[g] = !first_row && !first_col;
                end else if (g == int'(DIR_UP)) begin : g_up
                    assign prev_v[g]  = lb_rd[g];
                    assign prev_ok[g] = !first_row;
                end else begin : g_upr
                    assign prev_v[g]  = lb_rd[g];
                    assign prev_ok[g] = !first_row && !last_col;
                end
            end

            sgm_path_step #(.DMAX(DMAX), .CW(CW), .PENW(PENW), .PW(PW)) u_step (
                .clk(clk), .rst(rst), .chk(in_fire),
                .cost_i(in_cost), .prev_i(prev_v[g]), .prev_ok(prev_ok[g]),
                .p_small(pen_small), .p_large(pen_large), .path_o(path_v[g])
            );
        end
    endgenerate

    // left path in a register; previous-row upper-left saved before its slot is overwritten
    always_ff @(posedge clk) begin
        if (rst) begin
            left_reg <= '0;
            upl_hold <= '0;
        end else if (in_fire) begin
            left_reg <= path_v[int'(DIR_LEFT)];
            upl_hold <= lb_rd[int'(DIR_UPL)];
        end
    end

    generate
        for (g = 0; g < DMAX; g++) begin : g_sum
            always_comb begin
                logic [SW-1:0] acc;
                acc = '0;
                for (int k = 0; k < NDIR; k++)
                    acc = acc + {2'b00, path_v[k][g*PW +: PW]};
                sum_now[g*SW +: SW] = acc;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else if (in_fire) begin
            out_valid <= 1'b1;
            out_sum   <= sum_now;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_stall_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

    assert_fire_gives_valid_R1: assert property (@(posedge clk) disable iff (rst)
        in_fire |=> out_valid);

    assert_idle_left_state_R9: assert property (@(posedge clk) disable iff (rst)
        !in_fire |=> ($stable(left_reg) && $stable(upl_hold)));

endmodule

// File: tb/sim_sgm_agg4.sv
module sim_sgm_agg4;
    localparam int IMG_W = 5;
    localparam int IMG_H = 4;
    localparam int DMAX  = 4;
    localparam int CW    = 6;
    localparam int PENW  = 6;
    localparam int PW    = 7;
    localparam int SW    = PW + 2;
    localparam int VOUT  = DMAX * SW;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [DMAX*CW-1:0] in_cost = '0;
    logic [PENW-1:0]    pen_small = '0;
    logic [PENW-1:0]    pen_large = '0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [VOUT-1:0]    out_sum;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [VOUT-1:0] exp_q [$];
    string           tag_q [$];

    int cst [IMG_H][IMG_W][DMAX];
    int lp  [4][IMG_H][IMG_W][DMAX];

    always #4 clk = ~clk;

    sgm_agg4 #(.IMG_W(IMG_W), .IMG_H(IMG_H), .DMAX(DMAX), .CW(CW), .PENW(PENW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cost(in_cost), .pen_small(pen_small), .pen_large(pen_large),
        .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
    );

    task automatic check(input bit ok, input string req, input logic [VOUT-1:0] act,
                         input logic [VOUT-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // frame model straight from R4/R5: directions 0 left, 1 up-left, 2 up, 3 up-right
    task automatic model_frame(input int p1, input int p2);
        for (int y = 0; y < IMG_H; y++)
            for (int x = 0; x < IMG_W; x++)
                for (int r = 0; r < 4; r++) begin
                    int py, px, mn, cand;
                    bit ok;
                    py = (r == 0) ? y : y - 1;
                    px = (r == 0 || r == 1) ? x - 1 : (r == 2) ? x : x + 1;
                    ok = (py >= 0) && (px >= 0) && (px < IMG_W);
                    if (!ok) begin
                        for (int d = 0; d < DMAX; d++) lp[r][y][x][d] = cst[y][x][d];
                    end else begin
                        mn = lp[r][py][px][0];
                        for (int i = 1; i < DMAX; i++)
                            if (lp[r][py][px][i] < mn) mn = lp[r][py][px][i];
                        for (int d = 0; d < DMAX; d++) begin
                            cand = lp[r][py][px][d];
                            if (d > 0 && lp[r][py][px][d-1] + p1 < cand) cand = lp[r][py][px][d-1] + p1;
                            if (d < DMAX-1 && lp[r][py][px][d+1] + p1 < cand) cand = lp[r][py][px][d+1] + p1;
                            if (mn + p2 < cand) cand = mn + p2;
                            lp[r][y][x][d] = cst[y][x][d] + cand - mn;
                        end
                    end
                end
    endtask

    task automatic send_frame(input int p1, input int p2, input int pat,
                              input string ftag, input bit gaps);
        for (int y = 0; y < IMG_H; y++)
            for (int x = 0; x < IMG_W; x++)
                for (int d = 0; d < DMAX; d++)
                    case (pat)
                        0: cst[y][x][d] = int'($urandom % 64);
                        1: cst[y][x][d] = ((x + y + d) % 2 == 0) ? 63 : 0;
                        default: cst[y][x][d] = (d == (x + y) % DMAX) ? 0 : 40 + d;
                    endcase
        model_frame(p1, p2);
        pen_small = PENW'(p1);
        pen_large = PENW'(p2);
        for (int y = 0; y < IMG_H; y++)
            for (int x = 0; x < IMG_W; x++) begin
                logic [DMAX*CW-1:0] vec;
                logic [VOUT-1:0]    ev;
                string              tg;
                for (int d = 0; d < DMAX; d++) begin
                    int s;
                    vec[d*CW +: CW] = CW'(cst[y][x][d]);
                    s = lp[0][y][x][d] + lp[1][y][x][d] + lp[2][y][x][d] + lp[3][y][x][d];
                    ev[d*SW +: SW] = SW'(s);
                end
                if (x == 0 && y == 0) tg = {"R2 R7 ", ftag};
                else if (y == 0 || x == 0 || x == IMG_W-1) tg = {"R4 ", ftag};
                else tg = ftag;
                forever begin
                    @(negedge clk);
                    #2;
                    if (gaps && ($urandom % 3 == 0)) begin
                        in_valid = 1'b0;
                        in_cost  = ~vec;
                        continue;
                    end
                    in_valid = 1'b1;
                    in_cost  = vec;
                    #1;
                    if (in_ready) begin
                        exp_q.push_back(ev);
                        tag_q.push_back(tg);
                        @(posedge clk);
                        #1 in_valid = 1'b0;
                        break;
                    end
                end
            end
    endtask

    // monitor: drives back-pressure, pops and compares on every transfer
    initial begin
        logic [VOUT-1:0] held;
        bit stalled;
        stalled = 1'b0;
        held = '0;
        forever begin
            @(negedge clk);
            out_ready = ($urandom % 4 != 0);
            #1;
            if (!rst) begin
                if (stalled) begin
                    check(out_valid && out_sum == held, "R1 hold under stall", out_sum, held);
                end
                stalled = 1'b0;
                if (out_valid) begin
                    if (out_ready) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R1 unexpected output", out_sum, '0);
                        end else begin
                            logic [VOUT-1:0] e;
                            string t;
                            e = exp_q.pop_front();
                            t = tag_q.pop_front();
                            check(out_sum == e, t, out_sum, e);
                        end
                    end else begin
                        stalled = 1'b1;
                        held = out_sum;
                    end
                end
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 reset out_valid", VOUT'(out_valid), '0);
        check(in_ready == 1'b1 || out_ready == 1'b0, "R1 reset in_ready", VOUT'(in_ready), VOUT'(1));

        send_frame(3, 20, 0, "R5 R6", 1'b0);
        send_frame(0, 0, 0, "R8", 1'b0);
        send_frame(63, 63, 1, "R3", 1'b0);
        send_frame(5, 30, 0, "R9", 1'b1);
        send_frame(2, 9, 2, "R5", 1'b0);

        for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(posedge clk);
        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "R1 drain", VOUT'(exp_q.size()), '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule